// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block loads a configuration bitstream into a target FPGA through its slave-serial port. A start request first pulls the target's active-low program line low for a fixed time. On release the block checks that the target's completion flag (DONE) has dropped. It then waits out the target's power-up latency and shifts the bitstream bytes out serially, one bit per configuration clock.

Bytes arrive on a valid/ready stream, and a last flag marks the final byte. After the data the block keeps sending all-ones bytes until DONE rises, then sends one more all-ones byte and reports success. If DONE stays low past a completion timeout given in microseconds, it reports a timeout error instead. A request marked as partial reconfiguration is refused without touching the target. All delays come from a clock-frequency parameter. The configuration clock is the system clock divided down.

Top module: `ssl_cfg_loader`

## Requirements
- R1: Out of reset and whenever idle, `prog_n` is high, `cclk` is low, `s_ready` is low and `busy` is low.
- R2: An accepted start drives `prog_n` low for exactly PULSE_US·CLK_HZ/10^6 clock cycles. PULSE_US must represent at least 500 ns. `cclk` stays low during the pulse.
- R3: If `done_in` is high in the cycle after `prog_n` is released, the block stops with `err` = 1 (unexpected DONE) and produces no `cclk` edge.
- R4: The first rising `cclk` edge comes no sooner than LATENCY_US·CLK_HZ/10^6 cycles after `prog_n` rises.
- R5: Stream bytes go out in arrival order, MSB first, one bit per `cclk` period. `din` is sampled by the target on the rising edge of `cclk` and changes only while `cclk` is low.
- R6: `s_ready` is high only in the data phase, between bytes, while `cclk` is low.
- R7: If `done_in` is high when the last data byte has finished, exactly one 0xFF byte follows. Then `ok` rises with `err` = 0.
- R8: If `done_in` is low when the last data byte has finished, 0xFF bytes repeat and `done_in` is checked after each one. The first check that finds it high causes one final 0xFF byte, followed by `ok`.
- R9: If `done_in` is still low once `timeout_us` microseconds have passed after the data phase, the block stops at the next byte boundary. It then shows `err` = 2 (timeout) and `ok` = 0.
- R10: A start with `partial` high while idle sets `err` = 3 (rejected) in the next cycle. `busy` stays low, `prog_n` stays high and no `cclk` edge occurs.
- R11: `ok` and `err` hold their values until the next start accepted while idle. A start while busy is ignored, so it causes no second program pulse and does not disturb the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a load |
| partial | input | 1 | Marks the request as partial reconfiguration (refused) |
| timeout_us | input | TOUT_W | Completion timeout in microseconds, captured at start |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | `s_data` is valid |
| s_last | input | 1 | Current byte is the final one |
| s_ready | output | 1 | Block takes the byte at this edge when `s_valid` is high |
| prog_n | output | 1 | Active-low program/reset line to the target |
| cclk | output | 1 | Configuration clock to the target |
| din | output | 1 | Serial configuration data |
| done_in | input | 1 | Target's completion flag |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load completed (latched) |
| err | output | 2 | 0 none, 1 unexpected DONE, 2 timeout, 3 rejected (latched) |

## Verification
The assertions assume that `start` and `partial` change only between clock edges. They also assume that `done_in` is synchronous to `clk`, since the block samples it only at byte boundaries and right after the pulse. The bench changes every input on the falling edge of `clk`, and it raises DONE only at chosen byte counts, so the expected number of trailing all-ones bytes is exact. The stream never offers a byte outside the handshake, which keeps `s_valid` behaviour within what the ready-only-between-bytes property expects.

// File: rtl/ssl_cfg_loader.sv
module ssl_cfg_loader #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_US   = 1,
  parameter int LATENCY_US = 7500,
  parameter int CCLK_HALF  = 2,
  parameter int TOUT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              partial,
  input  logic [TOUT_W-1:0] timeout_us,
  input  logic [7:0]        s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              prog_n,
  output logic              cclk,
  output logic              din,
  input  logic              done_in,
  output logic              busy,
  output logic              ok,
  output logic [1:0]        err
);
  localparam int CYC_US    = CLK_HZ / 1_000_000;
  localparam int PULSE_CYC = PULSE_US * CYC_US;
  localparam int LAT_CYC   = LATENCY_US * CYC_US;
  localparam int PH_W      = $clog2(CCLK_HALF) + 1;
  localparam logic [1:0] E_NONE = 2'd0, E_DONE = 2'd1, E_TOUT = 2'd2, E_REJ = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_CHECK, S_WAIT, S_DATA, S_POST, S_TAIL} st_t;

  st_t               st;
  logic [31:0]       dly;
  logic [TOUT_W-1:0] us_cnt, tout_lim;
  logic [7:0]        sh;
  logic [3:0]        bits;
  logic [PH_W-1:0]   ph;
  logic              bact, last_seen;

  assign busy    = (st != S_IDLE);
  assign s_ready = (st == S_DATA) && !bact && !last_seen;
  assign din     = sh[7];

  wire ld_data = s_ready && s_valid;
  wire expired = (us_cnt >= tout_lim);
  wire ld_ff   = (st == S_POST) && !bact && (done_in || !expired);
  wire load    = ld_data || ld_ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= 8'hFF;
      bits <= '0;
      ph   <= '0;
      cclk <= 1'b0;
      bact <= 1'b0;
    end else if (load) begin
      sh   <= ld_data ? s_data : 8'hFF;
      bits <= 4'd8;
      ph   <= '0;
      cclk <= 1'b0;
      bact <= 1'b1;
    end else if (bact) begin
      if (ph == PH_W'(CCLK_HALF - 1)) begin
        ph   <= '0;
        cclk <= ~cclk;
        if (cclk) begin
          sh   <= {sh[6:0], 1'b1};
          bits <= bits - 4'd1;
          if (bits == 4'd1) bact <= 1'b0;
        end
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      prog_n    <= 1'b1;
      ok        <= 1'b0;
      err       <= E_NONE;
      dly       <= '0;
      us_cnt    <= '0;
      tout_lim  <= '0;
      last_seen <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ok <= 1'b0;
          if (partial) begin
            err <= E_REJ;
          end else begin
            err       <= E_NONE;
            prog_n    <= 1'b0;
            dly       <= '0;
            tout_lim  <= timeout_us;
            last_seen <= 1'b0;
            st        <= S_PULSE;
          end
        end
        S_PULSE: begin
          if (dly == 32'(PULSE_CYC - 1)) begin
            prog_n <= 1'b1;
            st     <= S_CHECK;
          end else begin
            dly <= dly + 32'd1;
          end
        end
        S_CHECK: begin
          if (done_in) begin
            err <= E_DONE;
            st  <= S_IDLE;
          end else begin
            dly <= '0;
            st  <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (dly == 32'(LAT_CYC - 1)) st <= S_DATA;
          else dly <= dly + 32'd1;
        end
        S_DATA: begin
          if (ld_data && s_last) last_seen <= 1'b1;
          if (!bact && last_seen) begin
            dly    <= '0;
            us_cnt <= '0;
            st     <= S_POST;
          end
        end
        S_POST: begin
          if (dly == 32'(CYC_US - 1)) begin
            dly <= '0;
            if (us_cnt != '1) us_cnt <= us_cnt + TOUT_W'(1);
          end else begin
            dly <= dly + 32'd1;
          end
          if (!bact) begin
            if (done_in) begin
              st <= S_TAIL;
            end else if (expired) begin
              err <= E_TOUT;
              st  <= S_IDLE;
            end
          end
        end
        S_TAIL: if (!bact) begin
          ok <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ssl_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       partial,
  input logic       s_ready,
  input logic       prog_n,
  input logic       cclk,
  input logic       din,
  input logic       busy,
  input logic       ok,
  input logic [1:0] err
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prog_n && !cclk && !s_ready));

  a_r2_pulse_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (busy && !cclk));

  a_r5_din_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(din));

  a_r6_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && prog_n && !cclk));

  a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && partial) |=> (!busy && prog_n && err == 2'd3));

  a_r11_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(ok) && $stable(err)));

  a_r7_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (err == 2'd0));
endmodule

bind ssl_cfg_loader ssl_cfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .partial(partial),
  .s_ready(s_ready), .prog_n(prog_n), .cclk(cclk), .din(din),
  .busy(busy), .ok(ok), .err(err)
);

// File: tb/tb_ssl_cfg_loader.sv
module tb_ssl_cfg_loader;
  localparam int PULSE_CYC = 50;
  localparam int LAT_CYC   = 500;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, partial = 1'b0;
  logic [15:0] timeout_us = 16'd50;
  logic [7:0]  s_data = 8'h00;
  logic        s_valid = 1'b0, s_last = 1'b0, done_in = 1'b0;
  logic        s_ready, prog_n, cclk, din, busy, ok;
  logic [1:0]  err;

  ssl_cfg_loader #(.CLK_HZ(50_000_000), .PULSE_US(1), .LATENCY_US(10),
                   .CCLK_HALF(2), .TOUT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .partial(partial),
    .timeout_us(timeout_us), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .prog_n(prog_n), .cclk(cclk),
    .din(din), .done_in(done_in), .busy(busy), .ok(ok), .err(err));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] expq[$];
  bit   allow_ff = 1'b0;
  int   bytes_seen = 0, rises = 0, falls = 0;
  int   low_len = 0, last_low = 0, lat = 0, last_lat = 0;
  bit   lat_run = 1'b0;
  logic pc = 1'b0, pp = 1'b1;
  logic [7:0] cap = 8'h00;
  int   nb = 0;

  task automatic chk(input bit c, input string req, input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: rebuild bytes from din at cclk rising edges, compare against queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prog_n) low_len++;
      if (pp && !prog_n) begin falls++; low_len = 1; end
      if (!pp && prog_n) begin last_low = low_len; lat = 0; lat_run = 1'b1; end
      else if (lat_run) lat++;
      if (cclk && !pc) begin
        rises++;
        if (lat_run) begin last_lat = lat; lat_run = 1'b0; end
        cap = {cap[6:0], din};
        nb++;
        if (nb == 8) begin
          nb = 0;
          bytes_seen++;
          if (expq.size() != 0) begin
            logic [7:0] e;
            e = expq.pop_front();
            chk(cap == e, "R5 serial byte", cap, e);
          end else begin
            chk(allow_ff && cap == 8'hFF, "R8 extra byte", cap, 255);
          end
        end
      end
      pc = cclk;
      pp = prog_n;
    end
  end

  task automatic pulse_start(input bit part);
    start = 1'b1; partial = part;
    @(negedge clk);
    start = 1'b0; partial = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // mode 0: DONE high during data; mode 1: DONE after n+3 bytes; mode 2: never
  task automatic run_load(input int n, input int mode, input int tmo);
    int b0, r0, f0;
    b0 = bytes_seen; r0 = rises; f0 = falls;
    timeout_us = 16'(tmo);
    done_in = 1'b0;
    for (int i = 0; i < n; i++)
      expq.push_back(i == 0 ? 8'h80 : (i == 1 ? 8'h01 : 8'((i * 37 + 5) & 255)));
    if (mode == 0) expq.push_back(8'hFF);
    if (mode == 1) repeat (4) expq.push_back(8'hFF);
    allow_ff = (mode == 2);
    pulse_start(1'b0);
    repeat (10) @(negedge clk);
    chk(prog_n == 1'b0, "R2 pulse active", prog_n, 0);
    chk(s_ready == 1'b0, "R6 ready low in pulse", s_ready, 0);
    repeat (200) @(negedge clk);
    chk(s_ready == 1'b0 && rises == r0, "R6 ready low in latency wait", s_ready, 0);
    for (int i = 0; i < n; i++) begin
      s_data  = i == 0 ? 8'h80 : (i == 1 ? 8'h01 : 8'((i * 37 + 5) & 255));
      s_last  = (i == n - 1);
      s_valid = 1'b1;
      while (!s_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
      if (i == 0 && mode == 0) begin
        done_in = 1'b1;
        pulse_start(1'b0);
      end
    end
    if (mode == 1) begin
      wait (bytes_seen == b0 + n + 3);
      done_in = 1'b1;
    end
    wait_idle();
    @(negedge clk);
    chk(last_low == PULSE_CYC, "R2 pulse width", last_low, PULSE_CYC);
    chk(last_lat >= LAT_CYC && last_lat <= LAT_CYC + 20, "R4 latency", last_lat, LAT_CYC);
    chk(falls - f0 == 1, "R11 single pulse", falls - f0, 1);
    if (mode == 2) begin
      chk(err == 2'd2 && !ok, "R9 timeout code", err, 2);
      chk(bytes_seen - b0 > n, "R9 fill bytes sent", bytes_seen - b0, n + 1);
    end else begin
      chk(ok && err == 2'd0, "R7 R8 success", ok, 1);
      chk(bytes_seen - b0 == n + (mode == 0 ? 1 : 4),
          mode == 0 ? "R7 one trailing byte" : "R8 trailing bytes",
          bytes_seen - b0, n + (mode == 0 ? 1 : 4));
    end
    chk(expq.size() == 0, "R5 all bytes seen", expq.size(), 0);
    repeat (40) @(negedge clk);
    chk(ok == (mode != 2) && err == (mode == 2 ? 2'd2 : 2'd0), "R11 status latched", err, mode == 2 ? 2 : 0);
    chk(!s_ready && prog_n && !cclk, "R1 idle after load", s_ready, 0);
    done_in = 1'b0;
    allow_ff = 1'b0;
    expq.delete();
  endtask

  initial begin
    int r0, f0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prog_n == 1'b1, "R1 prog_n idle", prog_n, 1);
    chk(cclk == 1'b0, "R1 cclk idle", cclk, 0);
    chk(s_ready == 1'b0, "R1 ready idle", s_ready, 0);
    chk(busy == 1'b0 && ok == 1'b0 && err == 2'd0, "R1 status idle", err, 0);

    r0 = rises; f0 = falls;
    pulse_start(1'b1);
    chk(err == 2'd3, "R10 reject code", err, 3);
    chk(!busy && prog_n, "R10 outputs untouched", busy, 0);
    repeat (20) @(negedge clk);
    chk(err == 2'd3 && falls == f0 && rises == r0, "R10 R11 no activity, code held", err, 3);

    done_in = 1'b1;
    r0 = rises;
    pulse_start(1'b0);
    chk(err == 2'd0, "R11 start clears status", err, 0);
    wait_idle();
    @(negedge clk);
    chk(err == 2'd1, "R3 unexpected DONE code", err, 1);
    chk(rises == r0, "R3 no cclk", rises - r0, 0);
    chk(last_low == PULSE_CYC, "R2 pulse width", last_low, PULSE_CYC);
    done_in = 1'b0;

    run_load(6, 0, 50);
    run_load(5, 1, 50);
    run_load(4, 2, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule